// File: doc/BRIEF.md
# Bus-Sharing Byte DMA Engine

This block is a single-channel DMA engine that borrows the processor's bus to copy bytes from a source to a destination. Either side may be memory, where the address steps up by one after each byte, or an I/O port, where the address stays the same for the whole run. Software sets a control byte and supplies base addresses, a byte count, a pacing divider and a watch address as plain configuration inputs. The engine copies each value into working registers at start, so the programmed values are only ever read.

Three run modes exist. Burst mode keeps the bus requested until the last byte has moved. Timed mode moves one byte per divider period and gives the bus back between bytes. The timed period is counted in ticks of a fast enable for memory-to-memory copies, or of a slow enable when either side is I/O. Timed mode can run once, or loop forever from the programmed bases. A watch comparator raises a sticky flag when a chosen memory address is read as a source or written as a destination.

Top module: `dma_xfer_engine`

## Requirements
- R1: Control byte layout: bits [1:0] are the mode (00 stopped, 01 burst once, 10 timed once, 11 timed looping), bit 2 set makes the destination an I/O port, bit 3 set makes the source an I/O port, and bit 4 picks the watched side (0 source reads, 1 destination writes). Bits [7:5] always read back as 0.
- R2: A run starts only when a nonzero mode is written while the mode reads 00. A control write with a nonzero mode during a run is ignored completely, and the read-back byte and the pacing do not change.
- R3: A memory side uses base, base+1, base+2 and so on. An I/O side presents its base address for every byte. Each byte is read once and then written once with the same data.
- R4: A run moves exactly the programmed count of bytes. A count of 0 moves 2^LEN_W bytes.
- R5: In burst mode, bus_req stays high from the first request until the last byte. Once grant is seen, a byte is written every 2 cycles.
- R6: In timed mode, one byte moves every pace_div ticks. The tick is fast_tick when both sides are memory and slow_tick when either side is I/O. bus_req is low between bytes.
- R7: In looping mode, after the last byte the engine reloads the bases and the count and carries on. done stays low and the mode reads 11.
- R8: Writing mode 00 stops any run. bus_req is low in the next cycle and no further strobes appear. A later start begins at the programmed bases with the full count.
- R9: When a run-once transfer ends, the mode field reads 00 and done is high for exactly one cycle.
- R10: probe_hit becomes 1 and stays set when the watched side accesses memory at probe_addr. probe_ack clears it. A new match in the same cycle as probe_ack wins.
- R11: After reset, the control byte reads 0, and bus_req, done, probe_hit and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte to write |
| ctrl_rd | output | 8 | Control byte read-back |
| src_base | input | ADDR_W | Programmed source address |
| dst_base | input | ADDR_W | Programmed destination address |
| xfer_len | input | LEN_W | Byte count, 0 meaning 2^LEN_W |
| pace_div | input | PRE_W | Ticks per byte in timed mode |
| probe_addr | input | ADDR_W | Watched memory address |
| probe_ack | input | 1 | Clears the watch flag |
| probe_hit | output | 1 | Sticky watch flag |
| fast_tick | input | 1 | Pacing enable for memory-to-memory |
| slow_tick | input | 1 | Pacing enable when I/O is involved |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read strobe, data sampled same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| io_addr | output | ADDR_W | I/O port address |
| io_rd | output | 1 | I/O read strobe, data sampled same cycle |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | DATA_W | I/O write data |
| io_rdata | input | DATA_W | I/O read data |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the engine with LEN_W set to 4, so that a zero count means 16 bytes and the wrap case finishes in a few dozen cycles. The 16-bit address and divider widths stay at their defaults. Fast ticks come every 2 cycles and slow ticks every 16, which gives an 8:1 ratio. With small divider values, the spacing between bytes in each pacing base, and the choice of base, can be measured exactly from write timestamps. Grant follows request one cycle late, so the request and release pattern between bytes can be seen at the ports.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_BURST = 2'b01,
    MODE_TIMED = 2'b10,
    MODE_LOOP  = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PACE,
    ST_REQ,
    ST_RD,
    ST_WR
  } seq_state_e;

  localparam int CTL_DST_IO   = 2;
  localparam int CTL_SRC_IO   = 3;
  localparam int CTL_PROBE_WR = 4;
  localparam int CTL_USED_W   = 5;

endpackage

// File: rtl/dma_pacer.sv
module dma_pacer #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             io_side,
  input  logic             fast_tick,
  input  logic             slow_tick,
  input  logic [PRE_W-1:0] pre,
  output logic             pace
);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W:0]   cnt_inc;
  logic             tick;
  logic             at_end;

  // Pick the pacing base: slow ticks whenever an I/O side is involved.
  assign tick    = io_side ? slow_tick : fast_tick;
  assign cnt_inc = {1'b0, cnt_q} + {{PRE_W{1'b0}}, 1'b1};
  // A divider of 0 or 1 fires on every tick.
  assign at_end  = cnt_inc >= {1'b0, pre};
  assign pace    = run & tick & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_end ? '0 : cnt_inc[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dma_probe.sv
module dma_probe #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              side_wr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              ack,
  output logic              hit
);

  logic hit_q, hit_d, match;

  assign match = (side_wr ? mem_wr : mem_rd) && (mem_addr == probe_addr);

  // A match in the same cycle as the acknowledge takes priority.
  always_comb begin
    hit_d = hit_q;
    if (ack)   hit_d = 1'b0;
    if (match) hit_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit = hit_q;

  // An acknowledge with no memory access in the same cycle leaves the flag clear.
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !mem_rd && !mem_wr) |=> !hit);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        start_mode,
  input  logic              stop,
  input  logic [1:0]        mode,
  input  logic              src_io,
  input  logic              dst_io,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              pace,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] io_addr,
  output logic              io_rd,
  output logic              io_wr,
  output logic [DATA_W-1:0] io_wdata,
  output logic              pace_run,
  output logic              finish,
  output logic              done
);

  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              pend_q, pend_d;
  logic              done_q;
  logic              last;
  logic              in_rd, in_wr;

  assign last  = (rem_q == LEN_ONE);
  assign in_rd = (state_q == ST_RD);
  assign in_wr = (state_q == ST_WR);

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    hold_d  = hold_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          src_d   = cfg_src;
          dst_d   = cfg_dst;
          rem_d   = cfg_len;
          state_d = (start_mode == MODE_BURST) ? ST_REQ : ST_PACE;
        end
      end
      ST_PACE: begin
        if (pend_q) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (bus_gnt) state_d = ST_RD;
      end
      ST_RD: begin
        hold_d = src_io ? io_rdata : mem_rdata;
        if (!src_io) src_d = src_q + ADDR_ONE;
        state_d = ST_WR;
      end
      ST_WR: begin
        if (!dst_io) dst_d = dst_q + ADDR_ONE;
        if (last) begin
          if (mode == MODE_LOOP) begin
            src_d   = cfg_src;
            dst_d   = cfg_dst;
            rem_d   = cfg_len;
            state_d = ST_PACE;
          end else begin
            finish  = !stop;
            state_d = ST_IDLE;
          end
        end else begin
          rem_d   = rem_q - LEN_ONE;
          state_d = (mode == MODE_BURST) ? ST_RD : ST_PACE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (stop) state_d = ST_IDLE;
  end

  // Pending pace pulse: at most one is held while a byte is in flight.
  always_comb begin
    if (start || stop)                      pend_d = 1'b0;
    else if (state_q == ST_PACE && pend_q)  pend_d = pace;
    else                                    pend_d = pend_q | pace;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      rem_q   <= rem_d;
      hold_q  <= hold_d;
      pend_q  <= pend_d;
      done_q  <= finish;
    end
  end

  assign bus_req   = (state_q == ST_REQ) || in_rd || in_wr;
  assign mem_rd    = in_rd && !src_io;
  assign io_rd     = in_rd &&  src_io;
  assign mem_wr    = in_wr && !dst_io;
  assign io_wr     = in_wr &&  dst_io;
  assign mem_addr  = mem_rd ? src_q : (mem_wr ? dst_q : '0);
  assign io_addr   = io_rd  ? src_q : (io_wr  ? dst_q : '0);
  assign mem_wdata = hold_q;
  assign io_wdata  = hold_q;
  assign pace_run  = (state_q != ST_IDLE) && mode[1];
  assign done      = done_q;

  assert_strobe_has_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |-> bus_gnt);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_burst_holds_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && mode == MODE_BURST && !finish && !stop) |=> bus_req);

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int PRE_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rd,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [PRE_W-1:0]  pace_div,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_ack,
  output logic              probe_hit,
  input  logic              fast_tick,
  input  logic              slow_tick,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] io_addr,
  output logic              io_rd,
  output logic              io_wr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              done
);

  localparam int PAD_W = 8 - CTL_USED_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // Control byte.
  logic [CTL_USED_W-1:0] ctl_q, ctl_d;
  logic                  running, wr_stop, wr_start, finish, pace, pace_run;

  assign running  = (ctl_q[1:0] != MODE_STOP);
  assign wr_stop  = ctrl_wr && (ctrl_wdata[1:0] == MODE_STOP);
  assign wr_start = ctrl_wr && !running && (ctrl_wdata[1:0] != MODE_STOP);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_stop || wr_start) begin
      ctl_d = ctrl_wdata[CTL_USED_W-1:0];
    end else if (finish) begin
      ctl_d[1:0] = MODE_STOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctl_q <= '0;
    else          ctl_q <= ctl_d;
  end

  assign ctrl_rd = {{PAD_W{1'b0}}, ctl_q};

  dma_pacer #(.PRE_W(PRE_W)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run       (pace_run),
    .io_side   (ctl_q[CTL_SRC_IO] | ctl_q[CTL_DST_IO]),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .pre       (pace_div),
    .pace      (pace)
  );

  dma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (wr_start),
    .start_mode (ctrl_wdata[1:0]),
    .stop       (wr_stop),
    .mode       (ctl_q[1:0]),
    .src_io     (ctl_q[CTL_SRC_IO]),
    .dst_io     (ctl_q[CTL_DST_IO]),
    .cfg_src    (src_base),
    .cfg_dst    (dst_base),
    .cfg_len    (xfer_len),
    .pace       (pace),
    .bus_gnt    (bus_gnt),
    .mem_rdata  (mem_rdata),
    .io_rdata   (io_rdata),
    .bus_req    (bus_req),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .pace_run   (pace_run),
    .finish     (finish),
    .done       (done)
  );

  dma_probe #(.ADDR_W(ADDR_W)) u_probe (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .side_wr    (ctl_q[CTL_PROBE_WR]),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .probe_addr (probe_addr),
    .ack        (probe_ack),
    .hit        (probe_hit)
  );

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl_wr && ctrl_wdata[1:0] == MODE_STOP) |=> !bus_req);

  assert_done_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> (ctrl_rd[1:0] == MODE_STOP));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl_rd[7:5] == 3'b000);

endmodule

// File: tb/dma_xfer_engine_test.sv
`timescale 1ns/1ps
module dma_xfer_engine_test;

  localparam int AW = 16;
  localparam int LW = 4;
  localparam int PW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_wr = 1'b0;
  logic [7:0]    ctrl_wdata = '0;
  logic [7:0]    ctrl_rd;
  logic [AW-1:0] src_base = '0, dst_base = '0, probe_addr = 16'hFFFF;
  logic [LW-1:0] xfer_len = '0;
  logic [PW-1:0] pace_div = '0;
  logic          probe_ack = 1'b0, probe_hit;
  logic          fast_tick = 1'b0, slow_tick = 1'b0;
  logic          bus_req, bus_gnt = 1'b0;
  logic [AW-1:0] mem_addr, io_addr;
  logic          mem_rd, mem_wr, io_rd, io_wr, done;
  logic [DW-1:0] mem_wdata, mem_rdata, io_wdata, io_rdata;

  always #4 clk = ~clk;

  logic [7:0]  mem [256];
  logic [7:0]  io_val = 8'hA0;
  logic [15:0] w_addr [64];
  logic [7:0]  w_data [64];
  int          w_cyc  [64];
  int          nw = 0, ndone = 0, cyc = 0;
  logic        port_bad = 1'b0, clr_log = 1'b0;
  logic [15:0] exp_port = '0;
  int          n_chk = 0, n_fail = 0;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign io_rdata  = io_val;

  dma_xfer_engine #(.ADDR_W(AW), .LEN_W(LW), .PRE_W(PW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
    .src_base(src_base), .dst_base(dst_base), .xfer_len(xfer_len), .pace_div(pace_div),
    .probe_addr(probe_addr), .probe_ack(probe_ack), .probe_hit(probe_hit),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .done(done));

  // Environment: ticks, delayed grant, memory, I/O source and write log.
  always @(posedge clk) begin
    cyc       <= cyc + 1;
    fast_tick <= (cyc % 2) == 1;
    slow_tick <= (cyc % 16) == 15;
    bus_gnt   <= bus_req;
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (io_rd)  io_val <= io_val + 8'd1;
    if (clr_log) begin
      nw <= 0; ndone <= 0; port_bad <= 1'b0;
    end else begin
      if (mem_wr || io_wr) begin
        if (nw < 64) begin
          w_addr[nw] <= mem_wr ? mem_addr : io_addr;
          w_data[nw] <= mem_wr ? mem_wdata : io_wdata;
          w_cyc[nw]  <= cyc;
        end
        nw <= nw + 1;
      end
      if ((io_rd || io_wr) && io_addr != exp_port) port_bad <= 1'b1;
      if (done) ndone <= ndone + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wctl(input logic [7:0] b);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = b;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic wait_w(input int n);
    int k = 0;
    while (nw < n && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [LW-1:0] l,
                       input logic [15:0] p);
    src_base = s; dst_base = d; xfer_len = l; pace_div = p;
    clear_log();
  endtask

  task automatic t_reset();
    chk(ctrl_rd == 8'h00, "R11 ctrl", ctrl_rd, 0);
    chk(!bus_req && !done && !probe_hit, "R11 outputs", {bus_req, done, probe_hit}, 0);
    chk(!mem_rd && !mem_wr && !io_rd && !io_wr, "R11 strobes",
        {mem_rd, mem_wr, io_rd, io_wr}, 0);
  endtask

  task automatic t_reserved();
    wctl(8'hE4);
    chk(ctrl_rd == 8'h04, "R1 reserved bits", ctrl_rd, 8'h04);
    wctl(8'h00);
  endtask

  task automatic t_burst();
    bit ok = 1;
    setup(16'h0010, 16'h0040, 4'd5, 16'd1);
    wctl(8'h01);
    wait_w(2);
    chk(bus_req, "R5 bus held mid-burst", bus_req, 1);
    wait_w(5); idle(4);
    for (int i = 0; i < 5; i++) if (mem[8'h40 + i] != pat(16 + i)) ok = 0;
    chk(ok, "R3 burst copy data", mem[8'h40], pat(16));
    chk(w_addr[4] == 16'h0044, "R3 dst increments", w_addr[4], 16'h44);
    chk(w_cyc[3] - w_cyc[2] == 2, "R5 burst spacing", w_cyc[3] - w_cyc[2], 2);
    chk(nw == 5, "R4 burst count", nw, 5);
    chk(ndone == 1, "R9 done one cycle", ndone, 1);
    chk(ctrl_rd[1:0] == 2'b00, "R9 mode cleared", ctrl_rd, 0);
    chk(!bus_req, "R5 bus released at end", bus_req, 0);
  endtask

  task automatic t_len_zero();
    setup(16'h0000, 16'h0090, 4'd0, 16'd1);
    wctl(8'h01);
    wait_w(16); idle(20);
    chk(nw == 16, "R4 zero count is 2^LEN_W", nw, 16);
    chk(w_addr[15] == 16'h009F, "R4 last address", w_addr[15], 16'h9F);
  endtask

  task automatic t_mem_to_io();
    bit ok = 1;
    exp_port = 16'h00DF;
    setup(16'h0020, 16'h00DF, 4'd3, 16'd2);
    wctl(8'h06);
    wait_w(2);
    chk(!bus_req, "R6 bus released between bytes", bus_req, 0);
    wait_w(3); idle(4);
    for (int i = 0; i < 3; i++) if (w_data[i] != pat(32 + i) || w_addr[i] != 16'h00DF) ok = 0;
    chk(ok, "R3 io dst fixed port data", w_data[0], pat(32));
    chk(!port_bad, "R3 io port constant", port_bad, 0);
    chk(w_cyc[2] - w_cyc[1] == 32, "R6 slow tick pacing", w_cyc[2] - w_cyc[1], 32);
    chk(ndone == 1, "R9 timed once done", ndone, 1);
  endtask

  task automatic t_io_to_mem();
    bit ok = 1;
    logic [7:0] base;
    exp_port = 16'h003B;
    setup(16'h003B, 16'h0080, 4'd4, 16'd1);
    base = io_val;
    wctl(8'h09);
    wait_w(4); idle(4);
    for (int i = 0; i < 4; i++) if (mem[8'h80 + i] != base + 8'(i)) ok = 0;
    chk(ok, "R3 io src to incrementing mem", mem[8'h83], base + 8'd3);
    chk(!port_bad, "R3 io src port constant", port_bad, 0);
  endtask

  task automatic t_timed_mem();
    setup(16'h0010, 16'h0050, 4'd4, 16'd3);
    wctl(8'h02);
    wait_w(1);
    wctl(8'h01);
    chk(ctrl_rd == 8'h02, "R2 write during run ignored", ctrl_rd, 8'h02);
    wait_w(4); idle(10);
    chk(w_cyc[3] - w_cyc[2] == 6, "R6 fast tick pacing", w_cyc[3] - w_cyc[2], 6);
    chk(w_cyc[2] - w_cyc[1] == 6, "R2 pacing kept after ignored write",
        w_cyc[2] - w_cyc[1], 6);
    chk(nw == 4 && ndone == 1, "R2 run completes unchanged", nw, 4);
  endtask

  task automatic t_loop_stop();
    int held;
    bit ok;
    setup(16'h0010, 16'h0060, 4'd3, 16'd4);
    wctl(8'h03);
    wait_w(5);
    ok = (w_addr[0] == 16'h60) && (w_addr[2] == 16'h62) && (w_addr[3] == 16'h60)
         && (w_addr[4] == 16'h61);
    chk(ok, "R7 loop reloads bases", w_addr[3], 16'h60);
    chk(ctrl_rd[1:0] == 2'b11, "R7 mode stays looping", ctrl_rd, 3);
    chk(ndone == 0, "R7 no done while looping", ndone, 0);
    wctl(8'h00);
    chk(!bus_req, "R8 bus released after stop", bus_req, 0);
    held = nw;
    idle(60);
    chk(nw == held, "R8 no strobes after stop", nw, held);
    chk(ndone == 0, "R8 stop gives no done", ndone, 0);
    setup(16'h0010, 16'h0060, 4'd3, 16'd4);
    wctl(8'h02);
    wait_w(3); idle(6);
    chk(w_addr[0] == 16'h0060, "R8 restart from base", w_addr[0], 16'h60);
    chk(nw == 3 && ndone == 1, "R8 restart full length", nw, 3);
  endtask

  task automatic t_probe();
    probe_addr = 16'h0012;
    setup(16'h0010, 16'h0040, 4'd4, 16'd1);
    wctl(8'h01);
    wait_w(4); idle(4);
    chk(probe_hit, "R10 source read hit", probe_hit, 1);
    @(negedge clk); probe_ack = 1'b1; @(negedge clk); probe_ack = 1'b0;
    chk(!probe_hit, "R10 ack clears", probe_hit, 0);
    setup(16'h0010, 16'h0040, 4'd4, 16'd1);
    wctl(8'h11);
    wait_w(4); idle(4);
    chk(!probe_hit, "R10 write side ignores reads", probe_hit, 0);
    probe_addr = 16'h0042;
    setup(16'h0010, 16'h0040, 4'd4, 16'd1);
    wctl(8'h11);
    wait_w(4); idle(4);
    chk(probe_hit, "R10 destination write hit", probe_hit, 1);
    chk(probe_hit, "R10 flag sticky", probe_hit, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reserved();
    t_burst();
    t_len_zero();
    t_mem_to_io();
    t_io_to_mem();
    t_timed_mem();
    t_loop_stop();
    t_probe();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule